// File: doc/BRIEF.md
# Partitioned Vector Integer ALU

This block is a one-cycle integer execution unit for a 128-bit vector data path. It takes two 128-bit operands, an operation code and a lane-size select. It treats the operands as 16 lanes of 8 bits, 8 lanes of 16 bits or 4 lanes of 32 bits, and applies the chosen operation to every lane in parallel. The lane size is chosen per operation.

The arithmetic is built on a single chain of 8-bit adder segments. The lane-size select cuts this chain at lane boundaries at run time, so carries and borrows stay inside their own lane. The compare operations write a mask in each lane: all ones when the lane test holds and all zeros when it does not.

A new operation may be issued on every clock. The registered result and its valid flag appear on the clock edge after the operation is accepted.

Top module: `simd_int_alu`

## Requirements
- R1: The lane-size select `lane_sel` is 2 bits. 00 gives sixteen 8-bit lanes, 01 gives eight 16-bit lanes and 10 gives four 32-bit lanes. Lane i occupies bits [i*W +: W] of the operands and of the result.
- R2: Add (opcode 000) gives a+b per lane, modulo 2^W. No carry passes from a lane into the lane above it.
- R3: Subtract (opcode 001) gives a-b per lane, modulo 2^W. No borrow passes between lanes.
- R4: AND (010), OR (011) and XOR (100) act bit by bit on all 128 bits. Their result is the same for every legal lane size.
- R5: Compare-equal (101) fills each lane with all ones when the two lane values are equal, and with all zeros otherwise.
- R6: Compare-greater (110) fills each lane with all ones when the lane of a is greater than the lane of b as signed two's complement, and with all zeros otherwise.
- R7: `lane_sel` = 11 is illegal. For any opcode, the result is zero and `out_valid` is still raised.
- R8: Opcode 111 has no operation. Its result is zero and `out_valid` is still raised.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. Back-to-back operations each give their own result one cycle later.
- R10: After a cycle with `in_valid` low, `result` keeps its previous value, whatever the operand inputs do.
- R11: While reset is asserted, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Operation is present on the inputs this cycle |
| opcode | input | 3 | Operation select (see R2 to R8) |
| lane_sel | input | 2 | Lane width select (see R1, R7) |
| op_a | input | 128 | First operand |
| op_b | input | 128 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered result |

## Verification
The bench builds the unit with its defaults: a 128-bit vector cut into 8-bit segments. These defaults bring all three cut patterns of the carry chain within reach, as well as the dropped carry out of the top lane. All-ones plus one and zero minus one operands put a carry or borrow at every segment edge, so any chain that is not cut at a lane boundary shows up as a wrong lane value. For compares, the operand pairs 0x80 against 0x7F, and equal lanes placed next to unequal ones, show whether the signed order and the lane masks are right at each width.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CEQ = 3'd5,
    OP_CGT = 3'd6,
    OP_NUL = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LANE_W8  = 2'd0,
    LANE_W16 = 2'd1,
    LANE_W32 = 2'd2,
    LANE_BAD = 2'd3
  } lane_sel_e;

endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int VEC_W = 128,
  parameter int SEG_W = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic [1:0]       lane_sel_i,
  output logic [VEC_W-1:0] sum_o
);
  localparam int SEGS = VEC_W / SEG_W;

  logic [SEGS-1:0]  cut;
  logic [SEGS-1:0]  cin;
  logic [SEGS-1:1]  carry;
  logic [VEC_W-1:0] b_eff;

  // a segment starts a new lane when its index is a multiple of the lane size in segments
  always_comb begin
    int spl;
    spl = 1 << lane_sel_i;
    for (int k = 0; k < SEGS; k++) begin
      cut[k] = ((k & (spl - 1)) == 0);
    end
  end

  assign b_eff = sub_i ? ~b_i : b_i;

  generate
    for (genvar g = 0; g < SEGS; g++) begin : g_seg
      if (g == 0) begin : g_first
        assign cin[g] = sub_i;
      end else begin : g_rest
        assign cin[g] = cut[g] ? sub_i : carry[g];
      end

      if (g < SEGS - 1) begin : g_carry
        assign {carry[g+1], sum_o[g*SEG_W +: SEG_W]} =
          {1'b0, a_i[g*SEG_W +: SEG_W]} + {1'b0, b_eff[g*SEG_W +: SEG_W]} +
          {{SEG_W{1'b0}}, cin[g]};
      end else begin : g_top
        assign sum_o[g*SEG_W +: SEG_W] =
          a_i[g*SEG_W +: SEG_W] + b_eff[g*SEG_W +: SEG_W] +
          {{(SEG_W-1){1'b0}}, cin[g]};
      end
    end
  endgenerate

  // R2: the number of cut points matches the number of lanes the select asks for
  always_comb begin
    if (lane_sel_i != 2'b11) begin
      cut_count_chk: assert ($countones(cut) == (SEGS >> lane_sel_i));
    end
  end

endmodule

// File: rtl/simd_lane_compare.sv
module simd_lane_compare #(
  parameter int VEC_W = 128,
  parameter int SEG_W = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [1:0]       lane_sel_i,
  output logic [VEC_W-1:0] eq_mask_o,
  output logic [VEC_W-1:0] gt_mask_o
);
  localparam int NSIZES = 3;

  logic [VEC_W-1:0] eq_v [NSIZES];
  logic [VEC_W-1:0] gt_v [NSIZES];

  generate
    for (genvar s = 0; s < NSIZES; s++) begin : g_size
      localparam int LW = SEG_W << s;
      localparam int NL = VEC_W / LW;
      for (genvar i = 0; i < NL; i++) begin : g_lane
        logic signed [LW-1:0] la, lb;
        assign la = a_i[i*LW +: LW];
        assign lb = b_i[i*LW +: LW];
        assign eq_v[s][i*LW +: LW] = {LW{la == lb}};
        assign gt_v[s][i*LW +: LW] = {LW{la > lb}};
      end
    end
  endgenerate

  always_comb begin
    eq_mask_o = '0;
    gt_mask_o = '0;
    if (lane_sel_i != 2'b11) begin
      eq_mask_o = eq_v[lane_sel_i];
      gt_mask_o = gt_v[lane_sel_i];
    end
  end

  // R6: a lane cannot be both equal and greater
  always_comb begin
    eq_gt_excl_chk: assert ((eq_mask_o & gt_mask_o) == '0);
  end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu #(
  parameter int VEC_W = 128,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       opcode,
  input  logic [1:0]       lane_sel,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  import simd_alu_pkg::*;

  localparam int NBYTES = VEC_W / 8;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  alu_op_e          op;
  lane_sel_e        sel;
  logic [VEC_W-1:0] sum;
  logic [VEC_W-1:0] eq_mask;
  logic [VEC_W-1:0] gt_mask;
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_q;

  // reset asserts at once and is released two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign op  = alu_op_e'(opcode);
  assign sel = lane_sel_e'(lane_sel);

  simd_lane_adder #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_add (
    .a_i        (op_a),
    .b_i        (op_b),
    .sub_i      (op == OP_SUB),
    .lane_sel_i (lane_sel),
    .sum_o      (sum)
  );

  simd_lane_compare #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_cmp (
    .a_i        (op_a),
    .b_i        (op_b),
    .lane_sel_i (lane_sel),
    .eq_mask_o  (eq_mask),
    .gt_mask_o  (gt_mask)
  );

  // next-state
  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res_d = sum;
      OP_AND:         res_d = op_a & op_b;
      OP_OR:          res_d = op_a | op_b;
      OP_XOR:         res_d = op_a ^ op_b;
      OP_CEQ:         res_d = eq_mask;
      OP_CGT:         res_d = gt_mask;
      default:        res_d = '0;
    endcase
    if (sel == LANE_BAD) res_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  function automatic logic bytes_uniform(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NBYTES; k++) begin
      if (v[k*8 +: 8] != 8'h00 && v[k*8 +: 8] != 8'hFF) ok = 1'b0;
    end
    return ok;
  endfunction

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  // R7
  illegal_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && lane_sel == 2'b11) |=> (result == '0));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(result));

  // R5
  cmp_uniform_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (opcode == 3'd5 || opcode == 3'd6)) |=> bytes_uniform(result));

endmodule

// File: tb/tb_simd_int_alu.sv
module tb_simd_int_alu;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   opcode;
  logic [1:0]   lane_sel;
  logic [127:0] op_a;
  logic [127:0] op_b;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;

  simd_int_alu dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .lane_sel  (lane_sel),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [127:0] ref_model(input logic [127:0] a, input logic [127:0] b,
                                             input logic [2:0] op, input logic [1:0] sel);
    logic [127:0] r, mask, sb, al, bl, v;
    int w;
    r = '0;
    if (sel == 2'b11) return r;
    w    = 8 << sel;
    mask = (128'd1 << w) - 128'd1;
    sb   = 128'd1 << (w - 1);
    for (int i = 0; i < 128 / w; i++) begin
      al = (a >> (i * w)) & mask;
      bl = (b >> (i * w)) & mask;
      case (op)
        3'd0: v = (al + bl) & mask;
        3'd1: v = (al - bl) & mask;
        3'd2: v = al & bl;
        3'd3: v = al | bl;
        3'd4: v = al ^ bl;
        3'd5: v = (al == bl) ? mask : '0;
        3'd6: v = ((al ^ sb) > (bl ^ sb)) ? mask : '0;
        default: v = '0;
      endcase
      r = r | (v << (i * w));
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation, check the registered result one cycle later
  task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                        input logic [2:0] op, input logic [1:0] sel);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; opcode = op; lane_sel = sel;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'd0, out_valid}, 128'd1);
    check(req, result, ref_model(a, b, op, sel));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; lane_sel = '0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {127'd0, out_valid}, 128'd0);
    check("R11 result in reset", result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_add();
    for (int s = 0; s < 3; s++) begin
      run_op("R2 add all-ones plus one", {128{1'b1}}, {16{8'h01}}, 3'd0, 2'(s));
      run_op("R1 lane width add", {16{8'h01}}, {128{1'b1}}, 3'd0, 2'(s));
      run_op("R2 add 7F plus 01", {16{8'h7F}}, {16{8'h01}}, 3'd0, 2'(s));
      for (int n = 0; n < 10; n++) run_op("R2 add random", rnd128(), rnd128(), 3'd0, 2'(s));
    end
    // explicit values, independent of the model
    run_op("R1 add 16-bit", {8{16'h00FF}}, {8{16'h0001}}, 3'd0, 2'd1);
    check("R1 add 16-bit literal", result, {8{16'h0100}});
  endtask

  task automatic t_sub();
    for (int s = 0; s < 3; s++) begin
      run_op("R3 sub zero minus one", 128'd0, {16{8'h01}}, 3'd1, 2'(s));
      run_op("R3 sub 80 minus 01", {16{8'h80}}, {16{8'h01}}, 3'd1, 2'(s));
      for (int n = 0; n < 10; n++) run_op("R3 sub random", rnd128(), rnd128(), 3'd1, 2'(s));
    end
    run_op("R3 sub 8-bit", 128'd0, {16{8'h01}}, 3'd1, 2'd0);
    check("R3 sub 8-bit literal", result, {16{8'hFF}});
  endtask

  task automatic t_logic();
    logic [127:0] a, b;
    for (int op = 2; op <= 4; op++) begin
      a = rnd128(); b = rnd128();
      for (int s = 0; s < 3; s++) run_op("R4 bitwise", a, b, 3'(op), 2'(s));
    end
  endtask

  task automatic t_cmp();
    logic [127:0] a;
    for (int s = 0; s < 3; s++) begin
      a = rnd128();
      run_op("R5 eq same", a, a, 3'd5, 2'(s));
      run_op("R5 eq mixed", {64'h0, a[63:0]}, {64'h1234_5678_9ABC_DEF0, a[63:0]}, 3'd5, 2'(s));
      run_op("R6 gt 80 vs 7F", {16{8'h80}}, {16{8'h7F}}, 3'd6, 2'(s));
      run_op("R6 gt 7F vs 80", {16{8'h7F}}, {16{8'h80}}, 3'd6, 2'(s));
      for (int n = 0; n < 8; n++) begin
        run_op("R5 eq random", rnd128(), rnd128(), 3'd5, 2'(s));
        run_op("R6 gt random", rnd128(), rnd128(), 3'd6, 2'(s));
      end
    end
    run_op("R6 gt 8-bit signed", {16{8'h80}}, {16{8'h7F}}, 3'd6, 2'd0);
    check("R6 gt 8-bit literal", result, 128'd0);
  endtask

  task automatic t_illegal();
    for (int op = 0; op < 8; op++) begin
      run_op("R7 illegal lane size", {128{1'b1}}, {16{8'h01}}, 3'(op), 2'd3);
      check("R7 illegal lane size zero", result, 128'd0);
    end
    for (int s = 0; s < 3; s++) begin
      run_op("R8 null opcode", {128{1'b1}}, {128{1'b1}}, 3'd7, 2'(s));
      check("R8 null opcode zero", result, 128'd0);
    end
  endtask

  task automatic t_back_to_back();
    logic [127:0] a0, b0, a1, b1;
    a0 = rnd128(); b0 = rnd128(); a1 = rnd128(); b1 = rnd128();
    @(negedge clk);
    in_valid = 1'b1; op_a = a0; op_b = b0; opcode = 3'd0; lane_sel = 2'd0;
    @(negedge clk);
    check("R9 first valid", {127'd0, out_valid}, 128'd1);
    check("R9 first result", result, ref_model(a0, b0, 3'd0, 2'd0));
    op_a = a1; op_b = b1; opcode = 3'd1; lane_sel = 2'd2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second valid", {127'd0, out_valid}, 128'd1);
    check("R9 second result", result, ref_model(a1, b1, 3'd1, 2'd2));
    @(negedge clk);
    check("R9 valid drops", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_hold();
    logic [127:0] held;
    run_op("R10 setup", rnd128(), rnd128(), 3'd4, 2'd1);
    held = result;
    for (int n = 0; n < 4; n++) begin
      op_a = rnd128(); op_b = rnd128(); opcode = 3'(n); lane_sel = 2'(n);
      @(negedge clk);
      check("R10 result held", result, held);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cmp();
    t_illegal();
    t_back_to_back();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule